// File: doc/BRIEF.md
# Doorway Occupancy Tracker

This block sits behind two presence sensors mounted one after the other across a doorway. The outer sensor is met first by someone walking in, and the inner sensor is met first by someone walking out. Each sensor reads 1 while a body is inside its detection area. The two areas overlap, so there is a position where both read 1 at once. The block follows a person through that shared zone and decides whether they passed fully in or fully out. It then issues a two-bit command to an up/down occupancy counter that it also contains.

Both raw sensor bits are first resynchronised to the block clock. A direction state machine tracks the ordered sequence of sensor pairs. It emits a non-zero command only on the final step of a complete passage, as a pulse one cycle long. A person who steps partway into the zone and turns back leaves the count unchanged. So does a sensor pattern that no single person can produce. The counter saturates at both ends.

Top module: `occ_doorway`

## Requirements
- R1: After reset, `count_o` is 0 and `cmd_o` is 2'b00.
- R2: The pair {`sense_out_i`,`sense_in_i`} stepping 00→10→11→01→00 gives `cmd_o` = 2'b10 for one cycle, and then raises `count_o` by one.
- R3: The pair stepping 00→01→11→10→00 gives `cmd_o` = 2'b11 for one cycle, and then lowers `count_o` by one.
- R4: A passage that reverses before it completes and returns to 00 gives no command and leaves `count_o` unchanged. Backing from the last step into the shared zone and then finishing still counts once.
- R5: `cmd_o` is 2'b00 in every idle and intermediate state. It never takes the value 2'b01, and a non-zero value never lasts longer than one cycle.
- R6: An increment at the maximum value 2^CNT_W−1 leaves `count_o` at that maximum.
- R7: A decrement at 0 leaves `count_o` at 0.
- R8: Each sensor passes through two flops. The command appears in the third cycle after the closing 00 is applied, and `count_o` changes in the cycle after that.
- R9: A pattern that cannot be the start of a passage, such as both sensors rising together from idle, is ignored until both sensors read 0 again. No command is issued, and the next proper passage counts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_out_i | input | 1 | Outer presence sensor, asynchronous |
| sense_in_i | input | 1 | Inner presence sensor, asynchronous |
| cmd_o | output | 2 | Counter command: 00 none, 10 up, 11 down |
| count_o | output | CNT_W | Current occupancy |

## Verification
The hardest cases to reach are the saturation edges. Reaching them takes a long run of complete passages from the ports, because only a full ordered walk moves the count. The bench builds the block with a narrow counter so that a few dozen passages reach both the top and the floor. It also mixes in turned-back walks and impossible jumps between full passages. This confirms that they never disturb the running total that the scoreboard predicts.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_UP   = 2'b10,
        CMD_DOWN = 2'b11
    } occ_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN1,
        ST_IN2,
        ST_IN3,
        ST_OUT1,
        ST_OUT2,
        ST_OUT3,
        ST_LOST
    } dir_state_e;

    typedef struct packed {
        dir_state_e st;
        occ_cmd_e   cmd;
    } dir_regs_t;

endpackage

// File: rtl/occ_sync.sv
module occ_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_d, meta_q;
    logic [WIDTH-1:0] stab_d, stab_q;

    always_comb begin
        meta_d = raw_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/occ_dir_fsm.sv
module occ_dir_fsm
    import occ_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pair_i,
    output occ_cmd_e   cmd_o
);
    dir_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.cmd = CMD_NONE;
        unique case (r_q.st)
            ST_IDLE: begin
                if (pair_i == 2'b10)      r_d.st = ST_IN1;
                else if (pair_i == 2'b01) r_d.st = ST_OUT1;
                else if (pair_i == 2'b11) r_d.st = ST_LOST;
            end
            ST_IN1: begin
                if (pair_i == 2'b11)      r_d.st = ST_IN2;
                else if (pair_i == 2'b00) r_d.st = ST_IDLE;
                else if (pair_i == 2'b01) r_d.st = ST_LOST;
            end
            ST_IN2: begin
                if (pair_i == 2'b01)      r_d.st = ST_IN3;
                else if (pair_i == 2'b10) r_d.st = ST_IN1;
                else if (pair_i == 2'b00) r_d.st = ST_IDLE;
            end
            ST_IN3: begin
                if (pair_i == 2'b00) begin
                    r_d.st  = ST_IDLE;
                    r_d.cmd = CMD_UP;
                end
                else if (pair_i == 2'b11) r_d.st = ST_IN2;
                else if (pair_i == 2'b10) r_d.st = ST_LOST;
            end
            ST_OUT1: begin
                if (pair_i == 2'b11)      r_d.st = ST_OUT2;
                else if (pair_i == 2'b00) r_d.st = ST_IDLE;
                else if (pair_i == 2'b10) r_d.st = ST_LOST;
            end
            ST_OUT2: begin
                if (pair_i == 2'b10)      r_d.st = ST_OUT3;
                else if (pair_i == 2'b01) r_d.st = ST_OUT1;
                else if (pair_i == 2'b00) r_d.st = ST_IDLE;
            end
            ST_OUT3: begin
                if (pair_i == 2'b00) begin
                    r_d.st  = ST_IDLE;
                    r_d.cmd = CMD_DOWN;
                end
                else if (pair_i == 2'b11) r_d.st = ST_OUT2;
                else if (pair_i == 2'b01) r_d.st = ST_LOST;
            end
            default: begin
                if (pair_i == 2'b00) r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cmd <= CMD_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o = r_q.cmd;

    // R2
    cmd_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd != CMD_NONE) |-> ($past(pair_i) == 2'b00));

    // R5
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd != CMD_NONE) |=> (r_q.cmd == CMD_NONE));

    // R5
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd != 2'b01));
endmodule

// File: rtl/occ_counter.sv
module occ_counter
    import occ_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  occ_cmd_e         cmd_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cmd_i == CMD_UP && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
        else if (cmd_i == CMD_DOWN && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R6
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_UP && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R7
    floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_DOWN && cnt_q == '0) |=> (cnt_q == '0));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_UP && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NONE) |=> $stable(cnt_q));
endmodule

// File: rtl/occ_doorway.sv
module occ_doorway
    import occ_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sense_out_i,
    input  logic             sense_in_i,
    output logic [1:0]       cmd_o,
    output logic [CNT_W-1:0] count_o
);
    logic [1:0] pair_sync;
    occ_cmd_e   cmd;

    occ_sync #(.WIDTH(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sense_out_i, sense_in_i}),
        .sync_o (pair_sync)
    );

    occ_dir_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pair_i (pair_sync),
        .cmd_o  (cmd)
    );

    occ_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .count_o (count_o)
    );

    assign cmd_o = cmd;
endmodule

// File: tb/test_occ_doorway.sv
module test_occ_doorway;
    localparam int W = 3;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_out = 1'b0;
    logic s_in = 1'b0;
    logic [1:0] cmd_o;
    logic [W-1:0] count_o;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit started = 0;
    bit done = 0;

    typedef struct packed {
        logic [1:0]   cmd;
        logic [W-1:0] cnt;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    occ_doorway #(.CNT_W(W)) i_occ_doorway (
        .clk(clk), .rst_n(rst_n), .sense_out_i(s_out), .sense_in_i(s_in),
        .cmd_o(cmd_o), .count_o(count_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic b, input int n);
        @(negedge clk);
        s_out = a;
        s_in = b;
        repeat (n - 1) @(negedge clk);
    endtask

    // final step with R8 latency check at the third negedge
    task automatic close_walk(input logic [1:0] exp_cmd);
        @(negedge clk);
        s_out = 1'b0;
        s_in = 1'b0;
        repeat (3) @(negedge clk);
        check(cmd_o == exp_cmd, "R8 cmd latency", cmd_o, exp_cmd);
        repeat (3) @(negedge clk);
    endtask

    task automatic walk_in();
        exp_t e;
        if (exp_cnt < MAXV) exp_cnt++;
        e.cmd = 2'b10;
        e.cnt = W'(exp_cnt);
        q.push_back(e);
        step(1, 0, 4); step(1, 1, 4); step(0, 1, 4);
        close_walk(2'b10);
    endtask

    task automatic walk_out();
        exp_t e;
        if (exp_cnt > 0) exp_cnt--;
        e.cmd = 2'b11;
        e.cnt = W'(exp_cnt);
        q.push_back(e);
        step(0, 1, 4); step(1, 1, 4); step(1, 0, 4);
        close_walk(2'b11);
    endtask

    // scoreboard monitor
    bit pend = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (started) begin
            if (pend) begin
                check(count_o == cur.cnt, "R2/R3/R6/R7 count", count_o, cur.cnt);
                pend = 0;
            end
            if (cmd_o != 2'b00) begin
                if (q.size() == 0) begin
                    check(0, "R4/R5/R9 unexpected cmd", cmd_o, 0);
                end else begin
                    cur = q.pop_front();
                    check(cmd_o == cur.cmd, "R2/R3 cmd code", cmd_o, cur.cmd);
                    pend = 1;
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(count_o == 0, "R1 count reset", count_o, 0);
        check(cmd_o == 2'b00, "R1 cmd reset", cmd_o, 0);
        rst_n = 1'b1;
        started = 1;
        repeat (3) @(negedge clk);

        walk_in();                  // R2
        walk_in();
        walk_out();                 // R3
        // R4 turn back in the shared zone
        step(1, 0, 4); step(1, 1, 4); step(1, 0, 4); step(0, 0, 8);
        check(count_o == W'(exp_cnt), "R4 turn back", count_o, exp_cnt);
        // R4 exit aborted after first sensor
        step(0, 1, 4); step(0, 0, 8);
        check(count_o == W'(exp_cnt), "R4 exit abort", count_o, exp_cnt);
        // R9 impossible start then a normal passage
        step(1, 1, 4); step(0, 1, 4); step(0, 0, 8);
        check(count_o == W'(exp_cnt), "R9 ignored", count_o, exp_cnt);
        walk_in();                  // R9 recovery
        // R4 wiggle back into the shared zone then finish
        begin
            exp_t e;
            exp_cnt++;
            e.cmd = 2'b10;
            e.cnt = W'(exp_cnt);
            q.push_back(e);
            step(1, 0, 4); step(1, 1, 4); step(0, 1, 4); step(1, 1, 4); step(0, 1, 4);
            close_walk(2'b10);
        end
        // R6 saturate at top
        for (int i = 0; i < MAXV + 2; i++) walk_in();
        check(count_o == MAXV, "R6 top", count_o, MAXV);
        // R7 saturate at floor
        for (int i = 0; i < MAXV + 2; i++) walk_out();
        check(count_o == 0, "R7 floor", count_o, 0);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R5 all commands seen", q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule